// File: doc/BRIEF.md
# Threshold Voltage Comparator Scanner

This block watches digitised channel samples in the background and raises an interrupt when a chosen sample crosses a programmed limit. It holds six independent comparators. Each picks one of sixteen 10-bit sample inputs, compares it against its own 10-bit limit, and fires either when the sample is strictly above the limit or when the sample is at or below it. The analog conversion happens elsewhere. The block only reads the sample values that are presented on its input bus.

A single shared period register sets how often the comparators are evaluated. All enabled comparators are evaluated together on the same scan tick. A comparator whose condition holds on a tick latches a sticky status bit. Software clears that bit by writing a one to it. The level interrupt output is asserted while any status bit is set whose interrupt enable is also set.

Software reaches every setting through a byte-wide register port. Each comparator has four bytes:
- control
- limit low byte
- limit high bits
- channel high bit

After these come two status bytes, holding three comparators each, and the period byte.

Top module: `vcmp_scanner`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low. The period is 0 after reset, so a scan tick occurs on every clock.
- R2: Comparator i uses offsets 4i to 4i+3, with i from 0 to 5. The bytes are laid out as follows:
  - Offset 4i is control: bits [2:0] hold the low channel bits, bit 3 selects above mode, bit 4 is the interrupt enable and bit 5 is the compare enable.
  - Offset 4i+1 is the limit bits [7:0].
  - Offset 4i+2 is the limit bits [9:8], held in bits [1:0].
  - Offset 4i+3 holds the channel high bit in bit 0.
  - Unused bits read 0.
  - Offset 0x1A is the period, and any other unlisted offset reads 0x00.
  - Every written field reads back.
- R3: The monitored channel number is {channel-high bit, control[2:0]}. Its sample is bits [10*ch+9 : 10*ch] of `samples`.
- R4: With control bit 3 set, the condition is sample > limit. With bit 3 clear, the condition is sample <= limit. A sample equal to the limit therefore triggers only the second mode.
- R5: A comparator whose compare enable is clear never sets its status bit.
- R6: Writing the period register sets the period to P and restarts the scan count. A tick then occurs on the (P+1)-th clock edge after the write, and on every P+1 edges after that. With P = 0, a tick occurs on every edge.
- R7: Status for comparators 0–2 sits in bits [2:0] at offset 0x18, and for comparators 3–5 in bits [2:0] at offset 0x19. Status bits stay set until cleared. Writing a one clears a bit and writing a zero leaves it unchanged.
- R8: If a status bit is set by a tick and cleared by a write on the same edge, it stays set.
- R9: `irq` is high exactly when some status bit is set together with its control bit 4. A status bit with its interrupt enable clear still sets and reads back.
- R10: A change to the limit or the mode takes effect on the first tick after the write edge. The evaluation on the write edge itself uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samples | input | 160 | Sixteen 10-bit channel samples, with channel k at bits [10k+9:10k] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the edge where the sample equals the limit. A design with a swapped comparison operator would set the bit in above mode or miss it in the at-or-below mode. It times the first ticks after a period write, where an off-by-one counter would latch status one clock early or late. It also tests a clear write that lands on a setting tick, where a design that gave priority to the clear would lose an event. It selects a channel above seven, where ignoring the channel high bit would watch the wrong input. The remaining fields are covered by a long random run checked against a reference model, including writes to the limit while a comparator is enabled.

// File: rtl/vcmp_scanner.sv
module vcmp_scanner #(
  parameter int NCMP = 6,
  parameter int SW   = 10,
  parameter int NCH  = 16,
  parameter int PW   = 8,
  parameter int AW   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] samples,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  localparam int HALF = NCMP / 2;
  localparam int HW   = SW - 8;
  localparam logic [AW-1:0] A_STLO = AW'(4 * NCMP);
  localparam logic [AW-1:0] A_STHI = AW'(4 * NCMP + 1);
  localparam logic [AW-1:0] A_PER  = AW'(4 * NCMP + 2);

  logic [NCMP-1:0] st, hit, cen, ien, setv, clr;
  logic [NCMP-1:0][3:0][7:0] fld;
  logic [PW-1:0] per, cnt;
  logic tick, per_wr;

  assign per_wr = reg_we && reg_addr == A_PER;
  assign tick   = (cnt == per);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per <= '0;
      cnt <= '0;
    end else if (per_wr) begin
      per <= reg_wdata[PW-1:0];
      cnt <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [5:0]    ctl;
    logic [SW-1:0] thr;
    logic          chh;
    logic [3:0]    ch;
    logic [SW-1:0] smp;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ctl <= '0;
        thr <= '0;
        chh <= 1'b0;
      end else if (reg_we) begin
        if (reg_addr == AW'(4*i))   ctl          <= reg_wdata[5:0];
        if (reg_addr == AW'(4*i+1)) thr[7:0]     <= reg_wdata;
        if (reg_addr == AW'(4*i+2)) thr[SW-1:8]  <= reg_wdata[HW-1:0];
        if (reg_addr == AW'(4*i+3)) chh          <= reg_wdata[0];
      end

    assign ch     = {chh, ctl[2:0]};
    assign smp    = samples[32'(ch)*SW +: SW];
    assign hit[i] = ctl[3] ? (smp > thr) : (smp <= thr);
    assign cen[i] = ctl[5];
    assign ien[i] = ctl[4];
    assign fld[i][0] = {2'b00, ctl};
    assign fld[i][1] = thr[7:0];
    assign fld[i][2] = 8'(thr[SW-1:8]);
    assign fld[i][3] = {7'b0, chh};
  end

  assign setv = {NCMP{tick}} & cen & hit;
  assign clr[HALF-1:0]    = (reg_we && reg_addr == A_STLO) ? reg_wdata[HALF-1:0] : '0;
  assign clr[NCMP-1:HALF] = (reg_we && reg_addr == A_STHI) ? reg_wdata[NCMP-HALF-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | setv;

  assign irq = |(st & ien);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STLO)      reg_rdata = 8'(st[HALF-1:0]);
    else if (reg_addr == A_STHI) reg_rdata = 8'(st[NCMP-1:HALF]);
    else if (reg_addr == A_PER)  reg_rdata = 8'(per);
    else if (32'(reg_addr[AW-1:2]) < NCMP)
      reg_rdata = fld[reg_addr[AW-1:2]][reg_addr[1:0]];
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == A_STLO || reg_addr == A_STHI)) |=> ((st & $past(st)) == $past(st)));

  p_set_only_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((st & ~$past(st)) == '0));

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st) & ~$past(cen)) == '0));

  p_clear_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_STLO) |=>
      ((st[HALF-1:0] & $past(reg_wdata[HALF-1:0] & ~setv[HALF-1:0])) == '0));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st != '0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick || per_wr) |=> (cnt == '0));
endmodule

// File: tb/sim_vcmp_scanner.sv
module sim_vcmp_scanner;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [159:0] samples;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  logic [9:0] smp [16];
  always_comb for (int k = 0; k < 16; k++) samples[k*10 +: 10] = smp[k];

  vcmp_scanner u0 (.clk(clk), .rst_n(rst_n), .samples(samples), .reg_we(reg_we),
                   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;

  // reference model built from the requirements
  logic [5:0] m_ctrl [6];
  logic [9:0] m_thr [6];
  logic [5:0] m_chh, m_st;
  logic [7:0] m_per, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    logic tk;
    logic [5:0] nset, clrm;
    logic [3:0] ch;
    logic [9:0] s;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin m_ctrl[i] = '0; m_thr[i] = '0; end
      m_chh = '0; m_st = '0; m_per = '0; m_cnt = '0;
    end else begin
      tk = (m_cnt == m_per);
      for (int i = 0; i < 6; i++) begin
        ch = {m_chh[i], m_ctrl[i][2:0]};
        s = smp[ch];
        nset[i] = tk && m_ctrl[i][5] && (m_ctrl[i][3] ? (s > m_thr[i]) : (s <= m_thr[i]));
      end
      clrm = '0;
      if (reg_we && reg_addr == 6'd24) clrm[2:0] = reg_wdata[2:0];
      if (reg_we && reg_addr == 6'd25) clrm[5:3] = reg_wdata[2:0];
      m_st = (m_st & ~clrm) | nset;
      if (reg_we && reg_addr == 6'd26) begin m_per = reg_wdata; m_cnt = '0; end
      else m_cnt = tk ? 8'd0 : m_cnt + 8'd1;
      if (reg_we && reg_addr < 6'd24) begin
        case (reg_addr[1:0])
          2'd0: m_ctrl[reg_addr[5:2]] = reg_wdata[5:0];
          2'd1: m_thr[reg_addr[5:2]][7:0] = reg_wdata;
          2'd2: m_thr[reg_addr[5:2]][9:8] = reg_wdata[1:0];
          default: m_chh[reg_addr[5:2]] = reg_wdata[0];
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [5:0] a);
    if (a < 6'd24) begin
      case (a[1:0])
        2'd0: return {2'b00, m_ctrl[a[5:2]]};
        2'd1: return m_thr[a[5:2]][7:0];
        2'd2: return {6'b0, m_thr[a[5:2]][9:8]};
        default: return {7'b0, m_chh[a[5:2]]};
      endcase
    end
    if (a == 6'd24) return {5'b0, m_st[2:0]};
    if (a == 6'd25) return {5'b0, m_st[5:3]};
    if (a == 6'd26) return m_per;
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [5:0] a);
    if (a < 6'd24) return (a[1:0] == 2'd0) ? "R2 ctrl" : (a[1:0] == 2'd3) ? "R3 chan-high" : "R2 limit";
    if (a == 6'd24 || a == 6'd25) return "R7 status";
    if (a == 6'd26) return "R6 period";
    return "R2 unmapped";
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(logic [5:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 chk(reg_rdata, exp, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] a;
    void'($urandom(32'd4242));
    for (int k = 0; k < 16; k++) smp[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int k = 0; k < 32; k++) rd(6'(k), 8'h00, "R1 reset");
    chk({7'b0, irq}, 8'h00, "R1 irq");
    // R2 field widths
    wr(6'd0, 8'hD7); rd(6'd0, 8'h17, "R2 ctrl mask");
    wr(6'd2, 8'hFF); rd(6'd2, 8'h03, "R2 limit high mask");
    wr(6'd3, 8'hFE); rd(6'd3, 8'h00, "R2 chan-high mask");
    wr(6'd0, 8'h00); wr(6'd2, 8'h00);
    // R4 equality, at-or-below mode triggers (comp1 on channel 2)
    smp[2] = 10'd100;
    wr(6'd5, 8'd100); wr(6'd6, 8'd0); wr(6'd4, 8'h22);
    rd(6'd24, 8'h00, "R10 write edge uses old ctrl");
    rd(6'd24, 8'h02, "R4 equal triggers at-or-below");
    chk({7'b0, irq}, 8'h00, "R9 irq masked");
    // R4 above mode: equal does not trigger
    wr(6'd4, 8'h2A); wr(6'd24, 8'h02);
    rd(6'd24, 8'h00, "R4 equal no trigger in above mode");
    rd(6'd24, 8'h00, "R4 stays clear");
    // R8 set beats clear
    wr(6'd4, 8'h22); wr(6'd24, 8'h02);
    rd(6'd24, 8'h02, "R8 set wins over clear");
    // R9 irq follows enable
    wr(6'd4, 8'h32); rd(6'd24, 8'h02, "R7 sticky");
    chk({7'b0, irq}, 8'h01, "R9 irq high");
    // R5 compare disabled
    wr(6'd4, 8'h12); wr(6'd24, 8'h07);
    rd(6'd24, 8'h00, "R5 disabled no set");
    rd(6'd24, 8'h00, "R5 disabled no set later");
    chk({7'b0, irq}, 8'h00, "R9 irq low");
    // R3 high channel select on comp4 (channel 11)
    smp[11] = 10'd900; smp[3] = 10'd0;
    wr(6'd17, 8'd244); wr(6'd18, 8'd1); wr(6'd19, 8'd1); wr(6'd16, 8'h2B);
    rd(6'd25, 8'h00, "R3 before first tick");
    rd(6'd25, 8'h02, "R3 channel 11 above limit");
    wr(6'd19, 8'd0); wr(6'd25, 8'h02);
    rd(6'd25, 8'h00, "R3 channel 3 below limit");
    wr(6'd16, 8'h00); wr(6'd4, 8'h00);
    // R6 period timing
    wr(6'd1, 8'hFF); wr(6'd2, 8'h03);
    wr(6'd26, 8'd4); wr(6'd0, 8'h20);
    for (int k = 0; k < 4; k++) rd(6'd24, 8'h00, "R6 no tick before P+1");
    rd(6'd24, 8'h01, "R6 tick at edge P+1");
    wr(6'd24, 8'h01);
    for (int k = 0; k < 3; k++) rd(6'd24, 8'h00, "R6 quiet between ticks");
    rd(6'd24, 8'h01, "R6 next tick P+1 later");
    // R10 limit change while enabled (period 0)
    wr(6'd26, 8'd0); wr(6'd0, 8'h28); wr(6'd24, 8'h07);
    smp[0] = 10'd50;
    wr(6'd1, 8'd10); wr(6'd2, 8'd0);
    rd(6'd24, 8'h00, "R10 old limit on write edge");
    rd(6'd24, 8'h01, "R10 new limit next tick");
    // random phase against the model
    wr(6'd0, 8'h00); wr(6'd24, 8'h07);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int k = 0; k < 16; k++) smp[k] = 10'($urandom_range(0, 1023));
      a = 6'($urandom_range(0, 28));
      reg_addr = a;
      reg_we = ($urandom_range(0, 2) == 0);
      reg_wdata = (a == 6'd26) ? 8'($urandom_range(0, 3)) : 8'($urandom);
      #1;
      chk(reg_rdata, exp_rd(a), tag_of(a));
      chk({7'b0, irq}, {7'b0, |(m_st & {m_ctrl[5][4], m_ctrl[4][4], m_ctrl[3][4],
                                         m_ctrl[2][4], m_ctrl[1][4], m_ctrl[0][4]})}, "R9 irq");
    end
    @(negedge clk); reg_we = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule